// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical byte address. It keeps four 16-bit segment registers: code, data, extra and stack. Each access presents its kind on an input. The kind picks a default segment register. An override input can force any of the four registers in its place. The chosen segment value is multiplied by sixteen, which appends four zero bits at the low end, and the offset is added to it. The sum wraps inside the 1,048,576-byte space.

Next to the physical address, the block reports the first and last byte of the selected segment. Each segment covers 64K bytes and starts on a 16-byte boundary. Segment registers load on the rising clock edge through a simple write port. All three address outputs follow the current register contents and the access inputs combinationally, with no clock edge in between.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is held low, and after it is released until the first write, all four segment registers read as 0000H. The physical address therefore equals the zero-extended offset, the segment start is 00000H and the segment end is 0FFFFH.
- R2: With `wr_en`=1, `wr_data` is stored into the register chosen by `wr_sel` (0 code, 1 data, 2 extra, 3 stack) at the rising clock edge. The new value affects the outputs only after that edge.
- R3: `phys_addr` equals the selected segment value times 16 plus the zero-extended `offset`, taken modulo 2^20. For example, 1000H:2000H gives 12000H.
- R4: With `ovr_en`=0, the selected segment follows `acc_kind`:
  - 0 (instruction fetch) selects code.
  - 1 (data) selects data.
  - 2 (stack through the stack pointer) selects stack.
  - 3 (stack through the base pointer) selects stack.
  - 4 (extra) selects extra.
  - The unused codes 5 to 7 select data.
- R5: With `ovr_en`=1, the selected segment is the one named by `ovr_sel` (same encoding as `wr_sel`), whatever `acc_kind` is.
- R6: `seg_start` equals the segment value times 16, so it always ends in four zero bits. `seg_end` equals `seg_start` plus FFFFH. Both are taken modulo 2^20.
- R7: A sum above FFFFFH wraps to the bottom of the space. For example, FFFFH:0010H gives 00000H, and the end of segment FFFFH is 0FFEFH.
- R8: The address outputs respond to a change of `offset`, `acc_kind`, `ovr_en` or `ovr_sel` within the same clock cycle, without waiting for an edge.
- R9: With `wr_en`=0, no segment register changes, whatever `wr_sel` and `wr_data` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; segment registers load on the rising edge |
| rst_n | input | 1 | Active-low reset; clears all segment registers |
| wr_en | input | 1 | Segment register write enable |
| wr_sel | input | 2 | Register to write: 0 code, 1 data, 2 extra, 3 stack |
| wr_data | input | 16 | Value to write into the chosen segment register |
| acc_kind | input | 3 | Kind of access, which picks the default segment |
| ovr_en | input | 1 | Use `ovr_sel` instead of the default segment |
| ovr_sel | input | 2 | Segment forced when `ovr_en` is 1 |
| offset | input | 16 | Offset within the segment |
| phys_addr | output | 20 | Physical byte address |
| seg_start | output | 20 | First byte of the selected segment |
| seg_end | output | 20 | Last byte of the selected segment |

## Verification
The hardest case to reach from the ports is wrap-around at the top of the address space. It needs a segment register already loaded near FFFFH and then an offset large enough to carry out of bit 19. The stimulus table first writes the segment registers through the write port, then applies fetch and overridden accesses against a code segment of FFFFH, so that both the physical address and the segment end overflow.

The table also holds overlapping segment/offset pairs that land on the same physical address. Directed steps probe the timing of the write port and show that a change of offset alone moves the outputs within a cycle.

// File: rtl/segaddr_pkg.sv
package segaddr_pkg;

    localparam int unsigned SEG_COUNT = 4;

    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_EXTRA = 2'd2,
        SEG_STACK = 2'd3
    } seg_id_e;

    typedef enum logic [2:0] {
        ACC_FETCH  = 3'd0,
        ACC_DATA   = 3'd1,
        ACC_STK_SP = 3'd2,
        ACC_STK_BP = 3'd3,
        ACC_EXTRA  = 3'd4
    } acc_kind_e;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
    parameter int unsigned SEG_W = 16,
    parameter int unsigned NSEG  = 4,
    localparam int unsigned IDX_W = $clog2(NSEG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_sel,
    input  logic [SEG_W-1:0]           wr_data,
    output logic [NSEG-1:0][SEG_W-1:0] seg_o
);

    typedef struct packed {
        logic [NSEG-1:0][SEG_W-1:0] seg;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            regs_d.seg[wr_sel] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign seg_o = regs_q.seg;

    // R2
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> seg_o[$past(wr_sel)] == $past(wr_data));

    // R9
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(seg_o));

endmodule

// File: rtl/seg_select.sv
module seg_select
    import segaddr_pkg::*;
#(
    parameter int unsigned ACC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] acc_kind,
    input  logic             ovr_en,
    input  logic [1:0]       ovr_sel,
    output logic [1:0]       sel
);

    logic [1:0] dflt_d;

    always_comb begin
        case (acc_kind)
            ACC_FETCH:  dflt_d = SEG_CODE;
            ACC_DATA:   dflt_d = SEG_DATA;
            ACC_STK_SP: dflt_d = SEG_STACK;
            ACC_STK_BP: dflt_d = SEG_STACK;
            ACC_EXTRA:  dflt_d = SEG_EXTRA;
            default:    dflt_d = SEG_DATA;
        endcase
        sel = ovr_en ? ovr_sel : dflt_d;
    end

    // R5
    ovr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_en |-> sel == ovr_sel);

    // R4
    fetch_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_en && acc_kind == ACC_FETCH) |-> sel == SEG_CODE);

    // R4
    stack_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_en && (acc_kind == ACC_STK_SP || acc_kind == ACC_STK_BP)) |-> sel == SEG_STACK);

endmodule

// File: rtl/addr_adder.sv
module addr_adder #(
    parameter int unsigned SEG_W = 16,
    parameter int unsigned OFF_W = 16,
    parameter int unsigned SHIFT = 4,
    localparam int unsigned AW   = SEG_W + SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEG_W-1:0] seg_val,
    input  logic [OFF_W-1:0] offset,
    output logic [AW-1:0]    phys,
    output logic [AW-1:0]    start,
    output logic [AW-1:0]    last
);

    logic [AW-1:0] off_ext;
    logic [AW-1:0] span;

    always_comb begin
        start   = {seg_val, {SHIFT{1'b0}}};
        off_ext = AW'(offset);
        span    = AW'({OFF_W{1'b1}});
        phys    = start + off_ext;
        last    = start + span;
    end

    // R3
    low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phys[SHIFT-1:0] == offset[SHIFT-1:0]);

    // R6
    start_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start[SHIFT-1:0] == '0);

    // R6
    end_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        &last[SHIFT-1:0]);

    // R7
    wrap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phys < start) |-> (phys < off_ext));

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import segaddr_pkg::*;
#(
    parameter int unsigned SEG_W = 16,
    parameter int unsigned OFF_W = 16,
    parameter int unsigned SHIFT = 4,
    parameter int unsigned ACC_W = 3,
    localparam int unsigned AW   = SEG_W + SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [SEG_W-1:0] wr_data,
    input  logic [ACC_W-1:0] acc_kind,
    input  logic             ovr_en,
    input  logic [1:0]       ovr_sel,
    input  logic [OFF_W-1:0] offset,
    output logic [AW-1:0]    phys_addr,
    output logic [AW-1:0]    seg_start,
    output logic [AW-1:0]    seg_end
);

    logic [SEG_COUNT-1:0][SEG_W-1:0] segs;
    logic [1:0]                      sel;
    logic [SEG_W-1:0]                seg_val_d;

    seg_regfile #(.SEG_W(SEG_W), .NSEG(SEG_COUNT)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .seg_o   (segs)
    );

    seg_select #(.ACC_W(ACC_W)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_kind (acc_kind),
        .ovr_en   (ovr_en),
        .ovr_sel  (ovr_sel),
        .sel      (sel)
    );

    always_comb begin
        seg_val_d = segs[sel];
    end

    addr_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_add (
        .clk     (clk),
        .rst_n   (rst_n),
        .seg_val (seg_val_d),
        .offset  (offset),
        .phys    (phys_addr),
        .start   (seg_start),
        .last    (seg_end)
    );

endmodule

// File: tb/tb_seg_addr_gen.sv
module tb_seg_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  acc_kind = '0;
    logic        ovr_en = 1'b0;
    logic [1:0]  ovr_sel = '0;
    logic [15:0] offset = '0;
    logic [19:0] phys_addr, seg_start, seg_end;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    seg_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .acc_kind(acc_kind), .ovr_en(ovr_en), .ovr_sel(ovr_sel), .offset(offset),
        .phys_addr(phys_addr), .seg_start(seg_start), .seg_end(seg_end)
    );

    typedef struct packed {
        logic [15:0] cs, ds, es, ss;
        logic [2:0]  acc;
        logic        oen;
        logic [1:0]  osel;
        logic [15:0] off;
        logic [19:0] e_phys, e_start, e_end;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        // R4 fetch -> code
        '{16'h1400, 16'h1000, 16'h52B9, 16'h5D27, 3'd0, 1'b0, 2'd0, 16'h1200, 20'h15200, 20'h14000, 20'h23FFF},
        // R4 data -> data
        '{16'h1400, 16'h1000, 16'h52B9, 16'h5D27, 3'd1, 1'b0, 2'd0, 16'h2000, 20'h12000, 20'h10000, 20'h1FFFF},
        // R4 extra, overlapping pair
        '{16'h1400, 16'h1000, 16'h52B9, 16'h5D27, 3'd4, 1'b0, 2'd0, 16'hD470, 20'h60000, 20'h52B90, 20'h62B8F},
        // R4 stack pointer, same physical address
        '{16'h1400, 16'h1000, 16'h52B9, 16'h5D27, 3'd2, 1'b0, 2'd0, 16'h2D90, 20'h60000, 20'h5D270, 20'h6D26F},
        // R4 base pointer -> stack
        '{16'hFFFF, 16'h1200, 16'h1201, 16'h2000, 3'd3, 1'b0, 2'd0, 16'h3000, 20'h23000, 20'h20000, 20'h2FFFF},
        // R6 paragraph start
        '{16'hFFFF, 16'h1200, 16'h1201, 16'h2000, 3'd1, 1'b0, 2'd0, 16'h0000, 20'h12000, 20'h12000, 20'h21FFF},
        // R6 next paragraph
        '{16'hFFFF, 16'h1200, 16'h1201, 16'h2000, 3'd4, 1'b0, 2'd0, 16'h0000, 20'h12010, 20'h12010, 20'h2200F},
        // R7 wrap to zero
        '{16'hFFFF, 16'h1200, 16'h1201, 16'h2000, 3'd0, 1'b0, 2'd0, 16'h0010, 20'h00000, 20'hFFFF0, 20'h0FFEF},
        // R5 fetch forced to stack
        '{16'hFFFF, 16'h1200, 16'h1201, 16'h2000, 3'd0, 1'b1, 2'd3, 16'h0000, 20'h20000, 20'h20000, 20'h2FFFF},
        // R5 stack forced to data
        '{16'hFFFF, 16'h1200, 16'h1201, 16'h2000, 3'd2, 1'b1, 2'd1, 16'h0005, 20'h12005, 20'h12000, 20'h21FFF},
        // R4 unused code 7 -> data
        '{16'hFFFF, 16'h1200, 16'h1201, 16'h2000, 3'd7, 1'b0, 2'd0, 16'h0000, 20'h12000, 20'h12000, 20'h21FFF},
        // R5 R7 unused code forced to code, wraps
        '{16'hFFFF, 16'h1200, 16'h1201, 16'h2000, 3'd5, 1'b1, 2'd0, 16'hFFFF, 20'h0FFEF, 20'hFFFF0, 20'h0FFEF}
    };

    task automatic check(input string what, input logic [19:0] got, input logic [19:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %05h expected %05h", what, got, exp);
        end
    endtask

    task automatic write_seg(input logic [1:0] id, input logic [15:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = id; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1 reset state
        acc_kind = 3'd1; offset = 16'h1234;
        repeat (2) @(negedge clk);
        #1;
        check("R1 phys in reset", phys_addr, 20'h01234);
        check("R1 start in reset", seg_start, 20'h00000);
        check("R1 end in reset", seg_end, 20'h0FFFF);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1 phys after release", phys_addr, 20'h01234);

        for (int i = 0; i < NV; i++) begin
            write_seg(2'd0, VECS[i].cs);
            write_seg(2'd1, VECS[i].ds);
            write_seg(2'd2, VECS[i].es);
            write_seg(2'd3, VECS[i].ss);
            acc_kind = VECS[i].acc; ovr_en = VECS[i].oen;
            ovr_sel = VECS[i].osel; offset = VECS[i].off;
            #1;
            check($sformatf("R3 phys vec %0d", i), phys_addr, VECS[i].e_phys);
            check($sformatf("R6 start vec %0d", i), seg_start, VECS[i].e_start);
            check($sformatf("R6 end vec %0d", i), seg_end, VECS[i].e_end);
        end

        // R2 write visible only after the edge (data segment currently 1200H)
        acc_kind = 3'd1; ovr_en = 1'b0; offset = 16'h0004;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'hABCD;
        #1;
        check("R2 before edge", phys_addr, 20'h12004);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R2 after edge", phys_addr, 20'hABCD4);

        // R9 data on the write port ignored without enable
        wr_sel = 2'd1; wr_data = 16'h5555;
        repeat (3) @(negedge clk);
        #1;
        check("R9 data seg kept", phys_addr, 20'hABCD4);
        wr_sel = 2'd0;
        @(negedge clk);
        acc_kind = 3'd0;
        #1;
        check("R9 code seg kept", seg_start, 20'hFFFF0);

        // R8 combinational response mid-cycle
        @(negedge clk);
        acc_kind = 3'd1; offset = 16'h0FFF;
        #1;
        check("R8 offset change", phys_addr, 20'hACCCF);
        ovr_en = 1'b1; ovr_sel = 2'd3;
        #1;
        check("R8 override change", phys_addr, 20'h20FFF);

        finish_run();
    end

endmodule